// File: doc/BRIEF.md
# I2C Slave Word-Access Bridge

This block is an I2C target that turns serial bus transactions into 32-bit word accesses on an internal register bus. A write transaction carries the device address, then a 22-bit word address as three bytes, then one data word as four bytes with the most significant byte first. The block acknowledges each byte. It raises a one-cycle write strobe only once the fourth data byte has been acknowledged. A STOP or a repeated START that arrives earlier abandons the write.

A read transaction carries only the device address with the read bit set. The block fetches the word at the most recently loaded address through a read-request strobe and shifts its four bytes out, most significant byte first. The stored address survives STOPs and traffic to other devices, and it never auto-increments. A static mode pin selects 7-bit or 10-bit device addressing.

Both bus lines pass through a synchroniser and a stability filter clocked by the oversampling system clock. Short spikes therefore never reach the protocol logic. The internal word interface has no back-pressure. The consumer must accept every write strobe in the cycle it is raised. It must present the read word on `rd_word` in the cycle after `rd_stb` and hold it there.

Top module: `i2c_word_bridge`

## Requirements
- R1: With `mode_10bit` low, a first byte whose upper seven bits equal `dev_id[6:0]` is acknowledged (bit 0 is R/W, 1 = read). Any other first byte is not acknowledged, and the rest of that transaction is ignored.
- R2: With `mode_10bit` high, a write is addressed by a first byte `11110`, `dev_id[9:8]`, `0`, followed by a second byte equal to `dev_id[7:0]`. The block acknowledges both bytes. A first byte with other ID bits, or a second byte that differs, is not acknowledged.
- R3: The three bytes after a write address are all acknowledged and set the word address. The low six bits of the first byte give bits 21:16, and its top two bits are ignored. The second byte gives bits 15:8 and the third gives bits 7:0. `word_addr` takes the new value only when the third byte completes.
- R4: The next four bytes are acknowledged and form the data word, the first byte being bits 31:24. `wr_stb` is high for exactly one cycle, after the acknowledge clock of the fourth byte. `wr_data` and `word_addr` are valid in that cycle.
- R5: A STOP or repeated START before the acknowledge of the fourth data byte produces no write strobe. An address whose third byte has completed is kept.
- R6: A read address is acknowledged. The block raises `rd_stb` for one cycle with `word_addr` valid and then returns the four bytes of `rd_word`, most significant first.
- R7: In 10-bit mode a read consists of the single first byte `11110`, `dev_id[9:8]`, `1`. It is acknowledged only while the block is still selected from its last complete 10-bit write address. This selection is lost when a 10-bit write address for another device is seen.
- R8: `word_addr` resets to zero. It persists across STOPs and transactions to other devices. Consecutive reads return the same word, with no auto-increment.
- R9: A fifth and any later write data byte is not acknowledged, and no second write strobe occurs.
- R10: During a read, the block drives nothing after the master does not acknowledge a byte, or after the fourth byte. The bus then reads as all ones. `sda_pull` is low after reset.
- R11: A pulse shorter than `GLITCH_CYCLES` clocks on SCL or SDA has no effect. `sda_pull` changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_10bit | input | 1 | Static addressing select: 0 = 7-bit, 1 = 10-bit |
| dev_id | input | 10 | Static device identifier (7-bit mode uses bits 6:0) |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| wr_stb | output | 1 | One-cycle word write strobe |
| wr_data | output | 32 | Word to write, valid with `wr_stb` |
| rd_stb | output | 1 | One-cycle word read request |
| rd_word | input | 32 | Read word, valid the cycle after `rd_stb` |
| word_addr | output | 22 | Stored word address for both writes and reads |

## Verification
The main path is swept over several arithmetic address/data pairs. The first address byte always has its two ignored bits set, so a wrongly decoded address or a misordered data byte shows up as a mismatch. Cancellation is tried after two data bytes with a STOP and after three with a repeated START. Together these separate a premature commit from a lost address. Reads are ended by a master NACK after one byte and by an over-long read of five bytes, which show whether the block releases the bus at the right byte. A write with short spikes injected on both lines, and a 10-bit run where another device's address comes between, cover filtering and the sticky 10-bit selection.

// File: rtl/i2cwb_pkg.sv
package i2cwb_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 22;
  localparam int DATA_BYTES = WORD_W / 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_HDR2,
    PH_MADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/i2cwb_glitch_filter.sv
module i2cwb_glitch_filter #(
  parameter int SYNC_STAGES  = 2,
  parameter int HOLD_CYCLES  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_cnt;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  // A new level is accepted only after it has stood for HOLD_CYCLES clocks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      run_cnt <= '0;
      clean   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      if (synced == clean) begin
        run_cnt <= '0;
      end else if (run_cnt == CW'(HOLD_CYCLES - 1)) begin
        clean   <= synced;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/i2cwb_line_events.sv
module i2cwb_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2cwb_ctrl.sv
module i2cwb_ctrl
  import i2cwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_10bit,
  input  logic [9:0]        dev_id,
  input  logic              sda_clean,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [WORD_W-1:0] rd_word,
  output logic              sda_pull,
  output logic              wr_stb,
  output logic [WORD_W-1:0] wr_data,
  output logic              rd_stb,
  output logic [ADDR_W-1:0] word_addr
);
  phase_t              phase, nxt_phase;
  logic [3:0]          bit_cnt;
  logic [6:0]          shreg;
  logic [7:0]          rx_byte;
  logic                ack_pend;
  logic [2:0]          byte_idx;
  logic [ADDR_W-9:0]   addr_hi;
  logic [WORD_W-1:0]   wbuf;
  logic [WORD_W-1:0]   txsh;
  logic                commit_pend;
  logic                tenbit_sel;
  logic                rd_load;
  logic                hdr10_id_ok;

  assign rx_byte     = {shreg, sda_clean};
  assign hdr10_id_ok = (rx_byte[7:3] == 5'b11110) && (rx_byte[2:1] == dev_id[9:8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      nxt_phase   <= PH_IDLE;
      bit_cnt     <= '0;
      shreg       <= '0;
      ack_pend    <= 1'b0;
      byte_idx    <= '0;
      addr_hi     <= '0;
      wbuf        <= '0;
      txsh        <= '0;
      commit_pend <= 1'b0;
      tenbit_sel  <= 1'b0;
      rd_load     <= 1'b0;
      sda_pull    <= 1'b0;
      wr_stb      <= 1'b0;
      wr_data     <= '0;
      rd_stb      <= 1'b0;
      word_addr   <= '0;
    end else begin
      wr_stb  <= 1'b0;
      rd_stb  <= 1'b0;
      rd_load <= rd_stb;
      if (rd_load) txsh <= rd_word;

      if (start_ev) begin
        phase       <= PH_HDR;
        bit_cnt     <= '0;
        byte_idx    <= '0;
        sda_pull    <= 1'b0;
        commit_pend <= 1'b0;
      end else if (stop_ev) begin
        phase       <= PH_IDLE;
        sda_pull    <= 1'b0;
        commit_pend <= 1'b0;
      end else if (phase != PH_IDLE && phase != PH_SKIP) begin
        if (scl_rise) begin
          if (bit_cnt < 4'd8) begin
            bit_cnt <= bit_cnt + 4'd1;
            if (phase != PH_RDATA) shreg <= rx_byte[6:0];
          end else if (bit_cnt == 4'd8) begin
            bit_cnt <= 4'd9;
            if (phase == PH_RDATA) begin
              // master acknowledge slot: NACK or fourth byte ends the read
              nxt_phase <= (sda_clean || byte_idx == 3'(DATA_BYTES - 1)) ? PH_SKIP : PH_RDATA;
            end
          end
          if (bit_cnt == 4'd7 && phase != PH_RDATA) begin
            ack_pend  <= 1'b0;
            nxt_phase <= PH_SKIP;
            unique case (phase)
              PH_HDR: begin
                if (!mode_10bit) begin
                  if (rx_byte[7:1] == dev_id[6:0]) begin
                    ack_pend  <= 1'b1;
                    byte_idx  <= '0;
                    if (rx_byte[0]) begin
                      nxt_phase <= PH_RDATA;
                      rd_stb    <= 1'b1;
                    end else begin
                      nxt_phase <= PH_MADDR;
                    end
                  end
                end else if (rx_byte[7:3] == 5'b11110) begin
                  if (!rx_byte[0]) begin
                    if (hdr10_id_ok) begin
                      ack_pend  <= 1'b1;
                      nxt_phase <= PH_HDR2;
                    end else begin
                      tenbit_sel <= 1'b0;
                    end
                  end else if (hdr10_id_ok && tenbit_sel) begin
                    ack_pend  <= 1'b1;
                    byte_idx  <= '0;
                    nxt_phase <= PH_RDATA;
                    rd_stb    <= 1'b1;
                  end
                end
              end
              PH_HDR2: begin
                if (rx_byte == dev_id[7:0]) begin
                  ack_pend   <= 1'b1;
                  tenbit_sel <= 1'b1;
                  byte_idx   <= '0;
                  nxt_phase  <= PH_MADDR;
                end else begin
                  tenbit_sel <= 1'b0;
                end
              end
              PH_MADDR: begin
                ack_pend <= 1'b1;
                if (byte_idx == 3'd0) begin
                  addr_hi[ADDR_W-9:8] <= rx_byte[ADDR_W-17:0];
                  byte_idx  <= 3'd1;
                  nxt_phase <= PH_MADDR;
                end else if (byte_idx == 3'd1) begin
                  addr_hi[7:0] <= rx_byte;
                  byte_idx  <= 3'd2;
                  nxt_phase <= PH_MADDR;
                end else begin
                  word_addr <= {addr_hi, rx_byte};
                  byte_idx  <= '0;
                  nxt_phase <= PH_WDATA;
                end
              end
              PH_WDATA: begin
                if (byte_idx < 3'(DATA_BYTES)) begin
                  ack_pend  <= 1'b1;
                  wbuf      <= {wbuf[WORD_W-9:0], rx_byte};
                  byte_idx  <= byte_idx + 3'd1;
                  nxt_phase <= PH_WDATA;
                  if (byte_idx == 3'(DATA_BYTES - 1)) commit_pend <= 1'b1;
                end
              end
              default: ;
            endcase
          end
        end else if (scl_fall) begin
          if (phase == PH_RDATA) begin
            if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
              txsh     <= txsh << 1;
              sda_pull <= ~txsh[WORD_W-2];
            end else if (bit_cnt == 4'd8) begin
              txsh     <= txsh << 1;
              sda_pull <= 1'b0;
            end else if (bit_cnt == 4'd9) begin
              bit_cnt  <= '0;
              byte_idx <= byte_idx + 3'd1;
              phase    <= nxt_phase;
              sda_pull <= (nxt_phase == PH_RDATA) ? ~txsh[WORD_W-1] : 1'b0;
            end
          end else begin
            if (bit_cnt == 4'd8) begin
              sda_pull <= ack_pend;
            end else if (bit_cnt == 4'd9) begin
              bit_cnt  <= '0;
              phase    <= nxt_phase;
              sda_pull <= (nxt_phase == PH_RDATA) ? ~txsh[WORD_W-1] : 1'b0;
              if (commit_pend) begin
                wr_stb      <= 1'b1;
                wr_data     <= wbuf;
                commit_pend <= 1'b0;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_word_bridge.sv
module i2c_word_bridge
  import i2cwb_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int GLITCH_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_10bit,
  input  logic [9:0]        dev_id,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic              wr_stb,
  output logic [WORD_W-1:0] wr_data,
  output logic              rd_stb,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  logic scl_clean, sda_clean;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2cwb_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .HOLD_CYCLES(GLITCH_CYCLES)
    ) u_flt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_lines[g]),
      .clean(clean_lines[g])
    );
  end

  assign scl_clean = clean_lines[0];
  assign sda_clean = clean_lines[1];

  i2cwb_line_events u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl     (scl_clean),
    .sda     (sda_clean),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  i2cwb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_10bit(mode_10bit),
    .dev_id    (dev_id),
    .sda_clean (sda_clean),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .rd_word   (rd_word),
    .sda_pull  (sda_pull),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .rd_stb    (rd_stb),
    .word_addr (word_addr)
  );
endmodule

// File: rtl/i2cwb_checker.sv
module i2cwb_checker
  import i2cwb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic              sda_pull,
  input logic [ADDR_W-1:0] word_addr,
  input logic              scl_clean,
  input logic              scl_rise,
  input logic              scl_fall
);
  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r4_wr_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(scl_fall));

  a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);

  a_r6_rd_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> $past(scl_rise));

  a_r8_addr_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_addr) |-> $past(scl_rise));

  a_r11_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_clean);
endmodule

bind i2c_word_bridge i2cwb_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_stb   (wr_stb),
  .rd_stb   (rd_stb),
  .sda_pull (sda_pull),
  .word_addr(word_addr),
  .scl_clean(scl_clean),
  .scl_rise (scl_rise),
  .scl_fall (scl_fall)
);

// File: tb/tb_i2c_word_bridge.sv
module tb_i2c_word_bridge;
  localparam int H = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_10bit = 1'b0;
  logic [9:0]  dev_id = 10'h2A5;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        sda_bus;
  logic        sda_pull, wr_stb, rd_stb;
  logic [31:0] wr_data;
  logic [31:0] rd_word = '0;
  logic [21:0] word_addr;

  int nchk = 0, nfail = 0, wr_cnt = 0, rd_cnt = 0, cyc = 0;
  logic [21:0] last_wa = '0;
  logic [31:0] last_wd = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  i2c_word_bridge dut (
    .clk(clk), .rst_n(rst_n), .mode_10bit(mode_10bit), .dev_id(dev_id),
    .scl_in(m_scl), .sda_in(sda_bus), .sda_pull(sda_pull),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
    .rd_word(rd_word), .word_addr(word_addr)
  );

  function automatic logic [31:0] mem_f(input logic [21:0] a);
    return 32'h9E3779B9 ^ {a, a[9:0]};
  endfunction

  always @(posedge clk) begin
    if (rd_stb) begin rd_word <= mem_f(word_addr); rd_cnt++; end
    if (wr_stb) begin wr_cnt++; last_wa <= word_addr; last_wd <= wr_data; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000 && !done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected<=180000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic ten);
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; mode_10bit = ten;
    wt(5); rst_n = 1'b1; wt(20);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(5);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
  endtask

  task automatic tx_byte(input logic [7:0] b, input bit glitch, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      if (glitch && i == 5) begin
        wt(8); m_scl = 1'b1; wt(3); m_scl = 1'b0; wt(H - 11);
      end else begin
        wt(H);
      end
      m_scl = 1'b1;
      if (glitch && i == 3) begin
        wt(8); m_sda = ~b[i]; wt(3); m_sda = b[i]; wt(H - 11);
      end else begin
        wt(H);
      end
      m_scl = 1'b0; wt(5);
    end
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H / 2);
    ack = ~sda_bus;
    wt(H / 2); m_scl = 1'b0; wt(5);
  endtask

  task automatic rx_byte(input bit ack_it, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H); m_scl = 1'b1; wt(H / 2); b[i] = sda_bus; wt(H / 2); m_scl = 1'b0; wt(5);
    end
    m_sda = ack_it ? 1'b0 : 1'b1;
    wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(5); m_sda = 1'b1;
  endtask

  // Sends address (ours unless hdr override), word address and ndata bytes; no STOP.
  task automatic do_write(input bit ten, input logic [7:0] hdr2, input logic [21:0] a,
                          input logic [31:0] d, input int ndata, input bit glitch,
                          output int acks, output logic last_ack);
    logic ak;
    logic [7:0] db;
    acks = 0;
    bus_start();
    if (ten) begin
      tx_byte(8'hF4, 1'b0, ak); acks += int'(ak);
      tx_byte(hdr2, 1'b0, ak); acks += int'(ak);
    end else begin
      tx_byte(hdr2, 1'b0, ak); acks += int'(ak);
    end
    tx_byte({2'b11, a[21:16]}, 1'b0, ak); acks += int'(ak);
    tx_byte(a[15:8], 1'b0, ak); acks += int'(ak);
    tx_byte(a[7:0], 1'b0, ak); acks += int'(ak);
    last_ack = ak;
    for (int i = 0; i < ndata; i++) begin
      db = (i < 4) ? d[31 - 8*i -: 8] : 8'h5A;
      tx_byte(db, glitch && i == 1, ak); acks += int'(ak);
      last_ack = ak;
    end
  endtask

  // Reads nbytes after a header; byte nack_at is not acknowledged (nor the last).
  task automatic do_read(input logic [7:0] hdr, input bit with_start, input int nbytes,
                         input int nack_at, output logic hack, output logic [39:0] bytes);
    logic [7:0] b;
    bytes = '1;
    if (with_start) bus_start();
    tx_byte(hdr, 1'b0, hack);
    for (int i = 0; i < nbytes; i++) begin
      rx_byte(!(i == nack_at || i == nbytes - 1), b);
      bytes[39 - 8*i -: 8] = b;
    end
    bus_stop();
  endtask

  initial begin
    int acks, w0;
    logic la, hk;
    logic [39:0] rb;
    logic [21:0] a, a_keep;
    logic [31:0] d;

    do_reset(1'b0);
    chk("R10 reset sda_pull", {31'd0, sda_pull}, 32'd0);
    chk("R4 reset wr_stb", {31'd0, wr_stb}, 32'd0);
    chk("R8 reset word_addr", {10'd0, word_addr}, 32'd0);

    // R1 R3 R4 R6 R8: sweep of addresses and data words in 7-bit mode
    for (int k = 0; k < 4; k++) begin
      a = 22'((k + 1) * 22'h0A3C5) ^ 22'(k << 20);
      d = 32'((k + 1) * 32'h1F2E3D4B);
      w0 = wr_cnt;
      do_write(1'b0, 8'h4A, a, d, 4, 1'b0, acks, la);
      bus_stop();
      chk("R1 R3 R4 write acks", 32'(acks), 32'd8);
      chk("R4 one write strobe", 32'(wr_cnt - w0), 32'd1);
      chk("R3 write address", {10'd0, last_wa}, {10'd0, a});
      chk("R4 write data", last_wd, d);
      do_read(8'h4B, 1'b1, 4, 9, hk, rb);
      chk("R6 read header ack", {31'd0, hk}, 32'd1);
      chk("R6 read word", rb[39:8], mem_f(a));
      do_read(8'h4B, 1'b1, 4, 9, hk, rb);
      chk("R8 repeat read same word", rb[39:8], mem_f(a));
    end
    a_keep = a;

    // R1 R8: another device's write is ignored and the address is kept
    w0 = wr_cnt;
    do_write(1'b0, 8'h4C, 22'h155555, 32'hDEADBEEF, 4, 1'b0, acks, la);
    bus_stop();
    chk("R1 foreign address no ack", 32'(acks), 32'd0);
    chk("R1 foreign no write", 32'(wr_cnt - w0), 32'd0);
    do_read(8'h4B, 1'b1, 4, 9, hk, rb);
    chk("R8 address persists", rb[39:8], mem_f(a_keep));

    // R5: STOP after two data bytes
    a = 22'h2ABCDE;
    w0 = wr_cnt;
    do_write(1'b0, 8'h4A, a, 32'h01234567, 2, 1'b0, acks, la);
    bus_stop();
    chk("R5 stop cancels write", 32'(wr_cnt - w0), 32'd0);
    do_read(8'h4B, 1'b1, 4, 9, hk, rb);
    chk("R5 address kept after stop", rb[39:8], mem_f(a));

    // R5: repeated START after three data bytes, directly into a read
    a = 22'h013579;
    w0 = wr_cnt;
    do_write(1'b0, 8'h4A, a, 32'h89ABCDEF, 3, 1'b0, acks, la);
    bus_start();
    do_read(8'h4B, 1'b0, 4, 9, hk, rb);
    chk("R5 repeated start cancels write", 32'(wr_cnt - w0), 32'd0);
    chk("R5 read after repeated start", rb[39:8], mem_f(a));

    // R9: fifth data byte refused
    a = 22'h3F00F0; d = 32'hA1B2C3D4;
    w0 = wr_cnt;
    do_write(1'b0, 8'h4A, a, d, 5, 1'b0, acks, la);
    bus_stop();
    chk("R9 fifth byte nacked", {31'd0, la}, 32'd0);
    chk("R9 ack count", 32'(acks), 32'd8);
    chk("R9 single write", 32'(wr_cnt - w0), 32'd1);
    chk("R9 data of first word", last_wd, d);

    // R10: master NACK after first byte, then an over-long read
    do_read(8'h4B, 1'b1, 2, 0, hk, rb);
    chk("R10 first byte", {24'd0, rb[39:32]}, {24'd0, mem_f(a)[31:24]});
    chk("R10 released after nack", {24'd0, rb[31:24]}, 32'h000000FF);
    do_read(8'h4B, 1'b1, 5, 9, hk, rb);
    chk("R10 four bytes", rb[39:8], mem_f(a));
    chk("R10 released after fourth", {24'd0, rb[7:0]}, 32'h000000FF);

    // R11: spikes on SCL and SDA during a data byte
    a = 22'h0F0F0F; d = 32'h5AC3_3CA5;
    w0 = wr_cnt;
    do_write(1'b0, 8'h4A, a, d, 4, 1'b1, acks, la);
    bus_stop();
    chk("R11 glitches ignored write", 32'(wr_cnt - w0), 32'd1);
    chk("R11 glitches ignored data", last_wd, d);

    // 10-bit mode
    do_reset(1'b1);
    chk("R8 reset word_addr 10-bit", {10'd0, word_addr}, 32'd0);
    do_read(8'hF5, 1'b1, 1, 9, hk, rb);
    chk("R7 read refused before selection", {31'd0, hk}, 32'd0);
    a = 22'h24680A; d = 32'hC0FFEE11;
    w0 = wr_cnt;
    do_write(1'b1, 8'hA5, a, d, 4, 1'b0, acks, la);
    bus_stop();
    chk("R2 10-bit write acks", 32'(acks), 32'd9);
    chk("R2 10-bit write data", last_wd, d);
    chk("R2 10-bit write addr", {10'd0, last_wa}, {10'd0, a});
    do_read(8'hF5, 1'b1, 4, 9, hk, rb);
    chk("R7 10-bit read ack", {31'd0, hk}, 32'd1);
    chk("R7 10-bit read word", rb[39:8], mem_f(a));
    do_write(1'b1, 8'h33, 22'h000001, 32'h0, 0, 1'b0, acks, la);
    bus_stop();
    chk("R2 other second byte nacked", 32'(acks), 32'd1);
    do_read(8'hF5, 1'b1, 1, 9, hk, rb);
    chk("R7 deselected by other device", {31'd0, hk}, 32'd0);
    do_read(8'hF2, 1'b1, 1, 9, hk, rb);
    chk("R2 other id bits nacked", {31'd0, hk}, 32'd0);
    do_write(1'b1, 8'hA5, a, d, 0, 1'b0, acks, la);
    bus_stop();
    do_read(8'hF5, 1'b1, 4, 9, hk, rb);
    chk("R7 reselected read ack", {31'd0, hk}, 32'd1);
    chk("R7 reselected read word", rb[39:8], mem_f(a));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule